// File: doc/BRIEF.md
# I2C Switch Bank Controller

This block is an I2C target that sets three banks of 4:1 analog switches and two general-purpose output pins. A controller writes commands in pairs of data bytes. The first byte of each pair picks a bank and an action. The second byte carries an active-low reset bit and the two GPO levels. Every command first updates a shadow copy of the configuration. The live outputs take the shadow contents only when a command arrives with its load flag set. That command and every staged command before it then reach the pins on the same clock edge.

A read transaction returns a 16-bit status word as two bytes, most significant bit first. The word shows the live state of every switch and both GPO pins. A hardware reset clears everything: all switches open, both GPOs low. A command whose reset bit is 0 has the same effect.

SCL and SDA are sampled through two-flop synchronizers on the system clock. The block drives SDA only by pulling it low through `sda_oe`.

Top module: `i2c_switch_bank`

## Requirements
- R1: The target acknowledges only an address byte whose upper seven bits equal {ADDR_HI, addr_pins} (defaults: ADDR_HI=4'b1001, and pins 3'b101 give write byte 8'h9A and read byte 8'h9B). It does not acknowledge any other address, and the rest of that transaction leaves the outputs unchanged.
- R2: A write is a sequence of command pairs (command byte, then second byte). In the command byte, bit 0 is the load flag. A complete pair with the load flag 0 and second-byte bit 0 high changes only the shadow state; `sw_closed` and `gpo` stay as they were.
- R3: A complete pair with the load flag 1 copies the shadow state, including that pair's own effect, onto `sw_closed` and `gpo` in a single clock edge.
- R4: Command bits [2:1] select bank 1, 2 or 3 (value 1..3). If bit 5 is 1, every input of that bank opens. Otherwise only the input chosen by bits [4:3] is closed (0=A .. 3=D). At most one input per bank is ever closed.
- R5: Command bits [2:1]=0 select the GPOs. The second byte's bit 1 is GPO1 (`gpo[0]`) and bit 2 is GPO2 (`gpo[1]`). These values are staged under the same load flag.
- R6: A complete pair whose second-byte bit 0 is 0 clears both the shadow and the live state at once: all switches open and both GPOs low.
- R7: While `rst_n` is low, and after it is released, all switches are open, both GPOs are low and SDA is released.
- R8: After it acknowledges a read address, the target sends the status word as two bytes, MSB first. Bit 15 is GPO1, bit 14 is GPO2, bits 13:12 are 0, and bits 11:0 match `sw_closed`. Bits 11..8 are bank 1 inputs A..D, bits 7..4 are bank 2 A..D and bits 3..0 are bank 3 A..D, where 1 means closed.
- R9: A STOP or repeated START in the middle of a transaction drops any partial byte or unfinished command pair and leaves the outputs unchanged.
- R10: The target never pulls SDA while idle, and it releases SDA on the cycle after a STOP is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| scl_in | input | 1 | I2C clock from the bus |
| sda_in | input | 1 | I2C data as seen on the bus |
| addr_pins | input | 3 | Low three bits of the target address |
| sda_oe | output | 1 | High pulls SDA low |
| sw_closed | output | 12 | Live switch state, same bit layout as status bits 11:0 |
| gpo | output | 2 | Live GPO levels, bit 0 is GPO1, bit 1 is GPO2 |

## Verification
The checker covers the rules that hold on every cycle:
- At most one closed input per bank.
- The live outputs change only on the edge after a completed command pair.
- A pair with load clear and reset high leaves the outputs frozen.
- A pair with reset low zeroes them.
- SDA stays quiet in idle and after a STOP.
- The hardware-reset state.

Only the bench scenarios can show:
- That several staged commands land together on a later load.
- That the status bytes come back in the right order and bit layout.
- That a foreign address is not acknowledged.
- That an aborted pair leaves no trace in the shadow state.

// File: rtl/i2c_switch_bank.sv
module i2c_switch_bank #(
  parameter logic [3:0] ADDR_HI = 4'b1001
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_in,
  input  logic        sda_in,
  input  logic [2:0]  addr_pins,
  output logic        sda_oe,
  output logic [11:0] sw_closed,
  output logic [1:0]  gpo
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_WR, S_ACK, S_RD, S_RACK} state_t;

  state_t      state;
  logic [1:0]  scl_sync, sda_sync;
  logic        scl_q, sda_q;
  logic [3:0]  cnt;
  logic [7:0]  sh, tx;
  logic [5:0]  cmd_q;
  logic        rw, byte_idx, rd_hi;
  logic [15:0] snap;
  logic [11:0] sh_sw, nx_sw;
  logic [1:0]  sh_gpo, nx_gpo;
  logic [3:0]  nib;

  wire scl     = scl_sync[1];
  wire sda     = sda_sync[1];
  wire scl_rise = scl & ~scl_q;
  wire scl_fall = ~scl & scl_q;
  wire start_c = scl & scl_q & sda_q & ~sda;
  wire stop_c  = scl & scl_q & ~sda_q & sda;
  wire in_idle = (state == S_IDLE);
  wire byte_end = scl_fall && (cnt == 4'd8);
  wire cmd_fire = (state == S_WR) && !start_c && !stop_c && byte_end && byte_idx;

  wire [15:0] status = {gpo[0], gpo[1], 2'b00, sw_closed};
  wire [7:0]  nbyte  = rd_hi ? snap[15:8] : snap[7:0];

  assign nib = cmd_q[5] ? 4'b0000 : (4'b1000 >> cmd_q[4:3]);

  always_comb begin
    nx_sw  = sh_sw;
    nx_gpo = sh_gpo;
    case (cmd_q[2:1])
      2'd0: nx_gpo = {sh[2], sh[1]};
      2'd1: nx_sw[11:8] = nib;
      2'd2: nx_sw[7:4]  = nib;
      default: nx_sw[3:0] = nib;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_sw <= '0; sh_gpo <= '0; sw_closed <= '0; gpo <= '0;
    end else if (cmd_fire) begin
      if (!sh[0]) begin
        sh_sw <= '0; sh_gpo <= '0; sw_closed <= '0; gpo <= '0;
      end else begin
        sh_sw  <= nx_sw;
        sh_gpo <= nx_gpo;
        if (cmd_q[0]) begin
          sw_closed <= nx_sw;
          gpo       <= nx_gpo;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= 2'b11; sda_sync <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
      state <= S_IDLE; cnt <= '0; sh <= '0; tx <= '0; cmd_q <= '0;
      rw <= 1'b0; byte_idx <= 1'b0; rd_hi <= 1'b1; snap <= '0; sda_oe <= 1'b0;
    end else begin
      scl_sync <= {scl_sync[0], scl_in};
      sda_sync <= {sda_sync[0], sda_in};
      scl_q <= scl;
      sda_q <= sda;
      if (start_c) begin
        state <= S_ADDR; cnt <= '0; byte_idx <= 1'b0; sda_oe <= 1'b0;
      end else if (stop_c) begin
        state <= S_IDLE; byte_idx <= 1'b0; sda_oe <= 1'b0;
      end else begin
        case (state)
          S_ADDR, S_WR: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda};
              cnt <= 4'(cnt + 1);
            end else if (byte_end) begin
              cnt <= '0;
              if (state == S_ADDR) begin
                if (sh[7:1] == {ADDR_HI, addr_pins}) begin
                  state <= S_ACK; sda_oe <= 1'b1; rw <= sh[0];
                  snap <= status; rd_hi <= 1'b1;
                end else begin
                  state <= S_IDLE;
                end
              end else begin
                state <= S_ACK; sda_oe <= 1'b1;
                byte_idx <= ~byte_idx;
                if (!byte_idx) cmd_q <= sh[5:0];
              end
            end
          end
          S_ACK, S_RACK: begin
            if (scl_rise) sh <= {sh[6:0], sda};
            if (scl_fall) begin
              cnt <= '0;
              if (!rw) begin
                sda_oe <= 1'b0; state <= S_WR;
              end else if (state == S_RACK && sh[0]) begin
                sda_oe <= 1'b0; state <= S_IDLE;
              end else begin
                sda_oe <= ~nbyte[7];
                tx     <= {nbyte[6:0], 1'b0};
                rd_hi  <= ~rd_hi;
                state  <= S_RD;
              end
            end
          end
          S_RD: begin
            if (scl_fall) begin
              cnt <= 4'(cnt + 1);
              if (cnt == 4'd7) begin
                sda_oe <= 1'b0; state <= S_RACK;
              end else begin
                sda_oe <= ~tx[7];
                tx     <= {tx[6:0], 1'b0};
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_switch_bank_chk.sv
module i2c_switch_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [11:0] sw_closed,
  input logic [1:0]  gpo,
  input logic        sda_oe,
  input logic        cmd_fire,
  input logic        load,
  input logic        rst_bit,
  input logic        stop_seen,
  input logic        idle
);

  a_r7_reset_clear: assert property (@(posedge clk)
    !rst_n |-> (sw_closed == 12'h000 && gpo == 2'b00 && !sda_oe));

  a_r4_one_per_bank: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(sw_closed[11:8]) <= 1) && ($countones(sw_closed[7:4]) <= 1) &&
    ($countones(sw_closed[3:0]) <= 1));

  a_r2_staged_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && !load && rst_bit) |=> ($stable(sw_closed) && $stable(gpo)));

  a_r3_change_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(sw_closed) && $stable(gpo)) |-> $past(cmd_fire));

  a_r6_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && !rst_bit) |=> (sw_closed == 12'h000 && gpo == 2'b00));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !sda_oe);

  a_r10_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> !sda_oe);

endmodule

bind i2c_switch_bank i2c_switch_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sw_closed(sw_closed), .gpo(gpo), .sda_oe(sda_oe),
  .cmd_fire(cmd_fire), .load(cmd_q[0]), .rst_bit(sh[0]),
  .stop_seen(stop_c), .idle(in_idle)
);

// File: tb/i2c_switch_bank_test.sv
module i2c_switch_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m_scl = 1'b1;
  logic        m_low = 1'b0;
  logic        sda_oe;
  logic [11:0] sw_closed;
  logic [1:0]  gpo;
  wire         sda_bus = ~(m_low | sda_oe);

  int total = 0, bad = 0;
  bit done = 0;

  localparam logic [7:0] WADR = 8'h9A, RADR = 8'h9B, XADR = 8'h98;
  localparam int NV = 9;
  localparam logic [7:0]  V_CMD[NV] = '{8'h0B, 8'h1C, 8'h06, 8'h01, 8'h1B, 8'h25, 8'h17, 8'h00, 8'h23};
  localparam logic [7:0]  V_B2 [NV] = '{8'h01, 8'h01, 8'h01, 8'h03, 8'h01, 8'h01, 8'h01, 8'h07, 8'h01};
  localparam logic [11:0] V_SW [NV] = '{12'h400, 12'h400, 12'h400, 12'h418, 12'h118, 12'h108, 12'h102, 12'h102, 12'h002};
  localparam logic [1:0]  V_GP [NV] = '{2'b00, 2'b00, 2'b00, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b11};

  i2c_switch_bank uut (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus),
    .addr_pins(3'b101), .sda_oe(sda_oe), .sw_closed(sw_closed), .gpo(gpo)
  );

  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic q;
    repeat (10) @(negedge clk);
  endtask

  task automatic i2c_start;
    m_low = 1'b0; q; m_scl = 1'b1; q; m_low = 1'b1; q; m_scl = 1'b0; q;
  endtask

  task automatic i2c_stop;
    m_low = 1'b1; q; m_scl = 1'b1; q; m_low = 1'b0; q;
  endtask

  task automatic send_bit(input logic b);
    m_low = ~b; q; m_scl = 1'b1; q; q; m_scl = 1'b0; q;
  endtask

  task automatic write_byte(input logic [7:0] b, output logic nack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_low = 1'b0; q; m_scl = 1'b1; q; nack = sda_bus; q; m_scl = 1'b0; q;
  endtask

  task automatic read_byte(input logic nack_in, output logic [7:0] b);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      q; m_scl = 1'b1; q; b[i] = sda_bus; q; m_scl = 1'b0;
    end
    q; m_low = ~nack_in; q; m_scl = 1'b1; q; q; m_scl = 1'b0; q; m_low = 1'b0;
  endtask

  task automatic write_cmd(input logic [7:0] c, input logic [7:0] b2);
    logic n;
    i2c_start; write_byte(WADR, n); write_byte(c, n); write_byte(b2, n); i2c_stop;
  endtask

  task automatic read_status(output logic [15:0] v, output logic nack);
    logic [7:0] hi, lo;
    i2c_start; write_byte(RADR, nack);
    read_byte(1'b0, hi); read_byte(1'b1, lo); i2c_stop;
    v = {hi, lo};
  endtask

  initial begin
    logic [15:0] st;
    logic n;
    repeat (5) @(negedge clk);
    check("R7 sw after reset", 32'(sw_closed), 0);
    check("R7 gpo after reset", 32'(gpo), 0);
    check("R7 sda released", 32'(sda_oe), 0);
    rst_n = 1'b1;
    q;
    read_status(st, n);
    check("R1 read address acked", 32'(n), 0);
    check("R8 status after reset", 32'(st), 0);

    for (int k = 0; k < NV; k++) begin
      write_cmd(V_CMD[k], V_B2[k]);
      check(V_CMD[k][0] ? "R3 R4 switches" : "R2 switches held", 32'(sw_closed), 32'(V_SW[k]));
      check(V_CMD[k][0] ? "R3 R5 gpo" : "R2 gpo held", 32'(gpo), 32'(V_GP[k]));
      read_status(st, n);
      check("R8 status word", 32'(st), 32'({V_GP[k][0], V_GP[k][1], 2'b00, V_SW[k]}));
    end

    i2c_start; write_byte(XADR, n);
    check("R1 foreign address not acked", 32'(n), 1);
    write_byte(8'h0B, n); write_byte(8'h01, n); i2c_stop;
    check("R1 foreign write ignored", 32'(sw_closed), 32'h002);

    i2c_start; write_byte(WADR, n); write_byte(8'h0B, n);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    i2c_stop;
    check("R9 stop mid byte", 32'(sw_closed), 32'h002);

    i2c_start; write_byte(WADR, n); write_byte(8'h0B, n);
    read_status(st, n);
    check("R9 repeated start keeps state", 32'(st), 32'hC002);
    write_cmd(8'h01, 8'h07);
    check("R9 dropped pair never staged", 32'(sw_closed), 32'h002);
    check("R5 gpo reload", 32'(gpo), 32'h3);

    write_cmd(8'h0B, 8'h00);
    check("R6 soft reset switches", 32'(sw_closed), 0);
    check("R6 soft reset gpo", 32'(gpo), 0);
    write_cmd(8'h01, 8'h01);
    check("R6 shadow cleared", 32'(sw_closed), 0);
    check("R6 shadow gpo cleared", 32'(gpo), 0);

    write_cmd(8'h0B, 8'h01);
    check("R4 bank1 B closed", 32'(sw_closed), 32'h400);
    rst_n = 1'b0;
    q;
    check("R7 hardware reset switches", 32'(sw_closed), 0);
    check("R7 hardware reset sda", 32'(sda_oe), 0);
    rst_n = 1'b1;
    q;
    write_cmd(8'h23, 8'h01);
    check("R10 sda idle after write", 32'(sda_oe), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule